// File: doc/BRIEF.md
# Windowed Power-Good Reset Supervisor

This block holds a processor in reset until the regulated supply that feeds it has been inside its tolerance band for a long, fixed time. Four threshold comparators watch the feedback node and report which thresholds the voltage is above. The block turns those flags into a window decision with hysteresis on both edges, filters changes of that decision against short disturbances, and only then starts a long release delay counted in ticks of a slow timebase. The reset output is active low and drives the gate of an open-drain pull-down: `0` pulls the line low, `1` lets it float high.

The output drops without waiting for the delay as soon as the filtered power-good state is lost, the regulator is disabled, or a reset request is raised. Only release is delayed. A reset request holds the output low while high. When it falls, the whole delay runs again from zero, provided the supply is in the window. With default parameters the filter spans 500 clocks (50 µs at 10 MHz) and the delay spans 200 one-millisecond ticks.

Top module: `pg_reset_supervisor`

## Requirements
- R1: After `rst_n` is released, `rst_out_n` is 0 and stays 0 until the release delay has run out, even if the voltage is in the window from the start.
- R2: The lower edge has hysteresis. `lo_set_cmp`=1 (voltage above 92 %) makes the lower edge satisfied. `lo_keep_cmp`=0 (voltage below 88 %) makes it unsatisfied. Between the two levels the previous state is kept.
- R3: The upper edge has hysteresis. `hi_trip_cmp`=1 (voltage above 108 %) makes the upper edge violated. `hi_clear_cmp`=0 (voltage below 105 %) makes it satisfied again. Between the two levels the previous state is kept.
- R4: The window decision (both edges satisfied) must differ from the filtered state for `FILT_CYCLES` consecutive clocks before the filtered state follows it. Shorter excursions are ignored.
- R5: While the block is qualified (filtered power-good, `enable`=1, `rst_req`=0), every clock with `tick_ms`=1 advances the delay count. `rst_out_n` becomes 1 on the clock after the `DELAY_TICKS`-th such tick, and not before.
- R6: When the filtered power-good state falls, `rst_out_n` goes to 0 on the next clock, without waiting for a tick.
- R7: While `rst_req` is 1, `rst_out_n` is 0 from the next clock on, whatever the power-good state. Ticks during that time do not count.
- R8: When `rst_req` falls while the voltage is in the window, the full delay of `DELAY_TICKS` ticks is needed again before release, including when the request interrupted a partly run delay.
- R9: Losing the filtered power-good state clears the delay count, so a partly run delay is lost.
- R10: `enable`=0 drives `rst_out_n` to 0 on the next clock and clears the delay count. After `enable` returns to 1, the full delay is needed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| tick_ms | input | 1 | One-clock pulse from the slow timebase that counts the release delay |
| lo_set_cmp | input | 1 | 1 when the feedback voltage is above 92 % of reference |
| lo_keep_cmp | input | 1 | 1 when the feedback voltage is above 88 % of reference |
| hi_trip_cmp | input | 1 | 1 when the feedback voltage is above 108 % of reference |
| hi_clear_cmp | input | 1 | 1 when the feedback voltage is above 105 % of reference |
| rst_req | input | 1 | Reset request. 1 holds the output low, and its fall restarts the delay |
| enable | input | 1 | Regulator enable. 0 forces reset and clears the delay |
| rst_out_n | output | 1 | Active-low reset to the processor (0 = pull the open-drain line low) |

## Verification
The bench drives the comparator flags as a set computed from one voltage level, so every pattern it applies is physically consistent. It visits 80, 85, 90, 95, 100, 106 and 110 percent. It approaches 90 % from above and from below, and 106 % from above and from below. Of these, the 90 % and 106 % levels separate a working hysteresis from a plain two-threshold window, because the expected output there depends only on the direction of approach.

Dips of the voltage shorter than the filter length tell a filter from a bare register. The bench also counts ticks exactly around the release point, one short of the delay and then the last one. That count is repeated after a reset request, after a disable, and after a partial delay cut by an excursion, which tells a restarted counter from one that only paused.

// File: rtl/pg_pkg.sv
package pg_pkg;

    // Lower / upper window edge state held by the hysteresis tracker.
    typedef struct packed {
        logic lo_ok;
        logic hi_ok;
    } win_state_t;

    // Phase of the release-delay timer.
    typedef enum logic [1:0] {
        TMR_HOLD  = 2'd0,
        TMR_COUNT = 2'd1,
        TMR_DONE  = 2'd2
    } tmr_phase_t;

endpackage

// File: rtl/pg_window_track.sv
module pg_window_track
    import pg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lo_set_cmp,
    input  logic lo_keep_cmp,
    input  logic hi_trip_cmp,
    input  logic hi_clear_cmp,
    output logic lo_ok,
    output logic hi_ok,
    output logic raw_good
);

    win_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // lower edge: set above the upper threshold, clear below the lower one
        if (lo_set_cmp) begin
            st_d.lo_ok = 1'b1;
        end else if (!lo_keep_cmp) begin
            st_d.lo_ok = 1'b0;
        end
        // upper edge: trip above the high threshold, clear below the low one
        if (hi_trip_cmp) begin
            st_d.hi_ok = 1'b0;
        end else if (!hi_clear_cmp) begin
            st_d.hi_ok = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{lo_ok: 1'b0, hi_ok: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign lo_ok    = st_q.lo_ok;
    assign hi_ok    = st_q.hi_ok;
    assign raw_good = st_q.lo_ok & st_q.hi_ok;

endmodule

// File: rtl/pg_glitch_filter.sv
module pg_glitch_filter #(
    parameter int FILT_CYCLES = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_good,
    output logic pg_filt
);

    generate
        if (FILT_CYCLES == 0) begin : g_bypass
            typedef struct packed {
                logic good;
            } byp_state_t;

            byp_state_t st_d, st_q;

            always_comb begin
                st_d      = st_q;
                st_d.good = raw_good;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end

            assign pg_filt = st_q.good;
        end else begin : g_count
            localparam int FCW = $clog2(FILT_CYCLES + 1);
            localparam logic [FCW-1:0] FLAST = FCW'(FILT_CYCLES - 1);

            typedef struct packed {
                logic           good;
                logic [FCW-1:0] cnt;
            } flt_state_t;

            flt_state_t st_d, st_q;

            always_comb begin
                st_d = st_q;
                if (raw_good == st_q.good) begin
                    st_d.cnt = '0;
                end else if (st_q.cnt == FLAST) begin
                    st_d.good = raw_good;
                    st_d.cnt  = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end

            assign pg_filt = st_q.good;
        end
    endgenerate

endmodule

// File: rtl/pg_release_timer.sv
module pg_release_timer
    import pg_pkg::*;
#(
    parameter int DELAY_TICKS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_ms,
    input  logic qualify,
    output logic expired
);

    localparam int CW = $clog2(DELAY_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(DELAY_TICKS);

    typedef struct packed {
        tmr_phase_t      phase;
        logic [CW-1:0]   cnt;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!qualify) begin
            st_d.phase = TMR_HOLD;
            st_d.cnt   = '0;
        end else if (st_q.phase != TMR_DONE && tick_ms) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt + 1'b1 == LAST) begin
                st_d.phase = TMR_DONE;
            end else begin
                st_d.phase = TMR_COUNT;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: TMR_HOLD, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign expired = (st_q.phase == TMR_DONE);

endmodule

// File: rtl/pg_reset_supervisor.sv
module pg_reset_supervisor #(
    parameter int FILT_CYCLES = 500,
    parameter int DELAY_TICKS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_ms,
    input  logic lo_set_cmp,
    input  logic lo_keep_cmp,
    input  logic hi_trip_cmp,
    input  logic hi_clear_cmp,
    input  logic rst_req,
    input  logic enable,
    output logic rst_out_n
);

    typedef struct packed {
        logic out_n;
    } top_state_t;

    logic       lo_ok;
    logic       hi_ok;
    logic       raw_good;
    logic       pg_filt;
    logic       qualify;
    logic       expired;
    top_state_t st_d, st_q;

    pg_window_track u_win (
        .clk         (clk),
        .rst_n       (rst_n),
        .lo_set_cmp  (lo_set_cmp),
        .lo_keep_cmp (lo_keep_cmp),
        .hi_trip_cmp (hi_trip_cmp),
        .hi_clear_cmp(hi_clear_cmp),
        .lo_ok       (lo_ok),
        .hi_ok       (hi_ok),
        .raw_good    (raw_good)
    );

    pg_glitch_filter #(
        .FILT_CYCLES(FILT_CYCLES)
    ) u_flt (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_good(raw_good),
        .pg_filt (pg_filt)
    );

    assign qualify = enable & pg_filt & ~rst_req;

    pg_release_timer #(
        .DELAY_TICKS(DELAY_TICKS)
    ) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_ms(tick_ms),
        .qualify(qualify),
        .expired(expired)
    );

    always_comb begin
        st_d       = st_q;
        st_d.out_n = qualify & expired;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_out_n = st_q.out_n;

endmodule

// File: rtl/pg_reset_supervisor_chk.sv
module pg_reset_supervisor_chk (
    input logic clk,
    input logic rst_n,
    input logic tick_ms,
    input logic lo_set_cmp,
    input logic lo_keep_cmp,
    input logic hi_trip_cmp,
    input logic hi_clear_cmp,
    input logic rst_req,
    input logic enable,
    input logic lo_ok,
    input logic hi_ok,
    input logic raw_good,
    input logic pg_filt,
    input logic rst_out_n
);

    assert_lo_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lo_set_cmp |=> lo_ok);

    assert_lo_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lo_keep_cmp |=> !lo_ok);

    assert_hi_trip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hi_trip_cmp |=> !hi_ok);

    assert_hi_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!hi_clear_cmp && !hi_trip_cmp) |=> hi_ok);

    assert_filter_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pg_filt) |-> (pg_filt == $past(raw_good)));

    assert_release_after_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out_n) |-> $past(tick_ms, 2));

    assert_high_needs_good_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_out_n |-> $past(pg_filt));

    assert_req_holds_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_out_n);

    assert_disable_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !rst_out_n);

endmodule

bind pg_reset_supervisor pg_reset_supervisor_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_ms     (tick_ms),
    .lo_set_cmp  (lo_set_cmp),
    .lo_keep_cmp (lo_keep_cmp),
    .hi_trip_cmp (hi_trip_cmp),
    .hi_clear_cmp(hi_clear_cmp),
    .rst_req     (rst_req),
    .enable      (enable),
    .lo_ok       (lo_ok),
    .hi_ok       (hi_ok),
    .raw_good    (raw_good),
    .pg_filt     (pg_filt),
    .rst_out_n   (rst_out_n)
);

// File: tb/sim_pg_reset_supervisor.sv
module sim_pg_reset_supervisor;

    localparam int CLK_PERIOD = 10;
    localparam int FILT       = 5;
    localparam int DELAY      = 8;

    logic clk = 1'b0;
    logic rst_n;
    logic tick_ms;
    logic lo_set_cmp;
    logic lo_keep_cmp;
    logic hi_trip_cmp;
    logic hi_clear_cmp;
    logic rst_req;
    logic enable;
    logic rst_out_n;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pg_reset_supervisor #(
        .FILT_CYCLES(FILT),
        .DELAY_TICKS(DELAY)
    ) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_ms     (tick_ms),
        .lo_set_cmp  (lo_set_cmp),
        .lo_keep_cmp (lo_keep_cmp),
        .hi_trip_cmp (hi_trip_cmp),
        .hi_clear_cmp(hi_clear_cmp),
        .rst_req     (rst_req),
        .enable      (enable),
        .rst_out_n   (rst_out_n)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_tick(input int n);
        for (int i = 0; i < n; i++) begin
            tick_ms = 1'b1;
            @(posedge clk);
            @(negedge clk);
            tick_ms = 1'b0;
        end
    endtask

    // comparator flags implied by one voltage level in percent of reference
    task automatic set_level(input int pct);
        lo_set_cmp   = (pct > 92);
        lo_keep_cmp  = (pct > 88);
        hi_trip_cmp  = (pct > 108);
        hi_clear_cmp = (pct > 105);
    endtask

    task automatic settle();
        step(FILT + 3);
    endtask

    // count the delay exactly: low one tick short, high one clock after the last
    task automatic run_delay(input string tag);
        pulse_tick(DELAY - 1);
        check(rst_out_n, 1'b0, {tag, " one tick short of delay"});
        pulse_tick(1);
        step(1);
        check(rst_out_n, 1'b1, {tag, " release after full delay"});
    endtask

    task automatic t_reset();
        rst_n = 1'b0; tick_ms = 1'b0; rst_req = 1'b0; enable = 1'b1;
        set_level(100);
        step(3);
        check(rst_out_n, 1'b0, "R1 output during reset");
        rst_n = 1'b1;
        settle();
        check(rst_out_n, 1'b0, "R1 held before any tick");
        run_delay("R5");
    endtask

    task automatic t_lower_hyst();
        set_level(90);
        settle();
        check(rst_out_n, 1'b1, "R2 90pct from above stays good");
        set_level(85);
        settle();
        check(rst_out_n, 1'b0, "R2 85pct is out of window");
        set_level(90);
        settle();
        pulse_tick(DELAY + 2);
        step(1);
        check(rst_out_n, 1'b0, "R2 90pct from below stays bad");
        set_level(95);
        settle();
        run_delay("R2");
    endtask

    task automatic t_upper_hyst();
        set_level(106);
        settle();
        check(rst_out_n, 1'b1, "R3 106pct from below stays good");
        set_level(110);
        settle();
        check(rst_out_n, 1'b0, "R3 110pct is out of window");
        set_level(106);
        settle();
        pulse_tick(DELAY + 2);
        step(1);
        check(rst_out_n, 1'b0, "R3 106pct from above stays bad");
        set_level(100);
        settle();
        run_delay("R3");
    endtask

    task automatic t_filter();
        set_level(85);
        step(FILT - 2);
        set_level(100);
        settle();
        check(rst_out_n, 1'b1, "R4 short dip ignored");
        set_level(85);
        step(FILT);
        check(rst_out_n, 1'b1, "R4 long dip not yet through filter");
        step(2);
        check(rst_out_n, 1'b0, "R6 reset asserted with no tick");
        set_level(100);
        settle();
        run_delay("R4");
    endtask

    task automatic t_request();
        rst_req = 1'b1;
        step(1);
        check(rst_out_n, 1'b0, "R7 request pulls output low");
        pulse_tick(DELAY + 2);
        step(1);
        check(rst_out_n, 1'b0, "R7 ticks during request ignored");
        rst_req = 1'b0;
        run_delay("R8");
        rst_req = 1'b1;
        step(1);
        rst_req = 1'b0;
        pulse_tick(DELAY - 2);
        rst_req = 1'b1;
        step(1);
        rst_req = 1'b0;
        run_delay("R8 restart after partial count");
    endtask

    task automatic t_window_clear();
        set_level(80);
        settle();
        check(rst_out_n, 1'b0, "R9 out of window");
        set_level(100);
        settle();
        pulse_tick(DELAY - 2);
        set_level(80);
        settle();
        set_level(100);
        settle();
        run_delay("R9");
    endtask

    task automatic t_enable();
        enable = 1'b0;
        step(1);
        check(rst_out_n, 1'b0, "R10 disable pulls output low");
        pulse_tick(DELAY + 2);
        step(1);
        check(rst_out_n, 1'b0, "R10 ticks while disabled ignored");
        enable = 1'b1;
        run_delay("R10");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        total++;
        $display("FAIL watchdog R1-chain actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_lower_hyst();
        t_upper_hyst();
        t_filter();
        t_request();
        t_window_clear();
        t_enable();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule